// File: doc/BRIEF.md
# Programmable Bus Cycle Timing Generator

This block turns one read or write request into a complete external memory bus cycle whose internal edges are all placed by configuration. A cycle counter starts at tick 0 when a request is taken and runs to a programmed last tick. Each of the following is a window of ticks, given by a start offset and a width: the address phase, the active-low read strobe, the active-low write strobe and the write-data drive. There is no wait or ready input from the memory, so every cycle has exactly the programmed length. On a read, the block captures the memory's data at a programmed tick. It then gives a one-clock done pulse with the captured word.

Requests use a valid/ready handshake. `req_ready` is high only when the generator is idle and the configuration is legal. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The address, data and direction are latched at that edge, so the requester may change them afterwards. The completion side has no back-pressure: `done` is a single-clock pulse, and `rd_data` keeps the last captured word until the next read captures a new one. The configuration inputs are expected to stay steady while a cycle runs. They are checked continuously, and an illegal setting raises `config_error`.

Tick k is the clock period that follows the k-th rising edge after the accepting edge. Tick 0 is the period right after acceptance. All bus outputs are registered and show their tick-k values during tick k.

Top module: `bus_cycle_timer`

## Requirements
- R1: `bus_addr_valid` is high and `bus_addr` equals the latched request address from tick `cfg_addr_dly` through tick `cfg_total-1`. At all other times `bus_addr_valid` is low and `bus_addr` is zero. On both reads and writes the address does not change while `bus_addr_valid` stays high.
- R2: A cycle lasts exactly `cfg_total` ticks. `done` is high for exactly one clock, in the period right after tick `cfg_total-1`. `req_ready` is low from acceptance until that period.
- R3: On a read, `bus_rd_n` is low for ticks `cfg_rd_dly` to `cfg_rd_dly+cfg_rd_wid-1` and high otherwise. On a write it stays high.
- R4: On a read, the value of `bus_rdata` present during tick `cfg_smp_dly` is shown on `rd_data` while `done` is high. `rd_data` keeps that value afterwards.
- R5: On a write, `bus_wr_n` is low for ticks `cfg_wr_dly` to `cfg_wr_dly+cfg_wr_wid-1` and high otherwise. On a read it stays high.
- R6: On a write, `bus_wdata_oe` is high and `bus_wdata` equals the latched write data for ticks `cfg_wd_dly` to `cfg_wd_dly+cfg_wd_wid-1`. At all other times `bus_wdata_oe` is low and `bus_wdata` is zero.
- R7: `config_error` is high whenever any of the following holds:
  - `cfg_total` is 0;
  - a strobe width is 0;
  - the read-strobe, write-strobe or write-data window ends beyond `cfg_total`;
  - `cfg_smp_dly` or `cfg_addr_dly` is not below `cfg_total`;
  - the write-data window starts after the write strobe starts;
  - the write-data window does not last at least one tick past the end of the write strobe.
- R8: While `config_error` is high, `req_ready` is low, a request is not taken, and both strobes stay high.
- R9: The strobes are never low together. After reset, both strobes are high, `bus_addr_valid`, `bus_wdata_oe` and `done` are low, and `req_ready` is high when the configuration is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_total | input | TW | Cycle length in ticks |
| cfg_addr_dly | input | TW | Tick at which the address is driven |
| cfg_rd_dly | input | TW | Read strobe start tick |
| cfg_rd_wid | input | TW | Read strobe width in ticks |
| cfg_smp_dly | input | TW | Read data capture tick |
| cfg_wr_dly | input | TW | Write strobe start tick |
| cfg_wr_wid | input | TW | Write strobe width in ticks |
| cfg_wd_dly | input | TW | Write data drive start tick |
| cfg_wd_wid | input | TW | Write data drive width in ticks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Idle with a legal configuration; request taken when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| bus_addr | output | AW | External address |
| bus_addr_valid | output | 1 | Address phase active |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DW | Data driven toward memory |
| bus_wdata_oe | output | 1 | Data drive enable |
| bus_rdata | input | DW | Data returned from memory |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Captured read data |
| config_error | output | 1 | Configuration is illegal |

## Verification
The bench changes the value on `bus_rdata` every tick. A sampler that is off by one tick, in either direction, therefore returns a visibly wrong word. Each window is checked tick by tick, with one setting where windows begin at tick 0 and run to the very last tick. An off-by-one compare at either end of a window would show up there as a strobe that is one tick short or one tick too long. The error tests use a capture tick placed at the cycle length, and a write-data window that starts after the write strobe. A checker with a lax bound would accept these settings and run a cycle with a strobe outside the legal frame. The cycle-length checks look for the done pulse in one exact period, which catches a counter that wraps one tick early or late.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum int unsigned {
    WIN_ADDR = 0,
    WIN_RD   = 1,
    WIN_WR   = 2,
    WIN_WD   = 3
  } win_e;
  localparam int NUM_WIN = 4;
endpackage

// File: rtl/bct_window.sv
module bct_window #(
  parameter int TW = 6
) (
  input  logic          en,
  input  logic [TW-1:0] tick,
  input  logic [TW-1:0] dly,
  input  logic [TW-1:0] wid,
  output logic          active
);
  localparam int EW = TW + 1;
  logic [EW-1:0] t_e, lo_e, hi_e;
  assign t_e  = {1'b0, tick};
  assign lo_e = {1'b0, dly};
  assign hi_e = {1'b0, dly} + {1'b0, wid};
  assign active = en && (t_e >= lo_e) && (t_e < hi_e);
endmodule

// File: rtl/bct_cfg_check.sv
module bct_cfg_check #(
  parameter int TW = 6
) (
  input  logic [TW-1:0] total,
  input  logic [TW-1:0] addr_dly,
  input  logic [TW-1:0] rd_dly,
  input  logic [TW-1:0] rd_wid,
  input  logic [TW-1:0] smp_dly,
  input  logic [TW-1:0] wr_dly,
  input  logic [TW-1:0] wr_wid,
  input  logic [TW-1:0] wd_dly,
  input  logic [TW-1:0] wd_wid,
  output logic          err
);
  localparam int EW = TW + 2;
  logic [EW-1:0] tot_e, rd_end, wr_end, wd_end;
  assign tot_e  = EW'(total);
  assign rd_end = EW'(rd_dly) + EW'(rd_wid);
  assign wr_end = EW'(wr_dly) + EW'(wr_wid);
  assign wd_end = EW'(wd_dly) + EW'(wd_wid);

  always_comb begin
    err = 1'b0;
    if (total == '0)               err = 1'b1;
    if (rd_wid == '0)              err = 1'b1;
    if (wr_wid == '0)              err = 1'b1;
    if (rd_end > tot_e)            err = 1'b1;
    if (wr_end > tot_e)            err = 1'b1;
    if (wd_end > tot_e)            err = 1'b1;
    if (smp_dly >= total)          err = 1'b1;
    if (addr_dly >= total)         err = 1'b1;
    if (wd_dly > wr_dly)           err = 1'b1;
    if (wd_end < wr_end + 1'b1)    err = 1'b1;
  end
endmodule

// File: rtl/bct_sequencer.sv
module bct_sequencer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [TW-1:0] last,
  output logic          busy,
  output logic [TW-1:0] tick,
  output logic          nxt_busy,
  output logic [TW-1:0] nxt_tick,
  output logic          done
);
  logic at_last;
  assign at_last = busy && (tick == last);

  always_comb begin
    nxt_busy = busy;
    nxt_tick = tick;
    if (busy) begin
      if (tick == last) begin
        nxt_busy = 1'b0;
        nxt_tick = '0;
      end else begin
        nxt_tick = tick + 1'b1;
      end
    end else if (accept) begin
      nxt_busy = 1'b1;
      nxt_tick = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
      done <= 1'b0;
    end else begin
      busy <= nxt_busy;
      tick <= nxt_tick;
      done <= at_last;
    end
  end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import bct_pkg::*;
#(
  parameter int TW = 6,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_total,
  input  logic [TW-1:0] cfg_addr_dly,
  input  logic [TW-1:0] cfg_rd_dly,
  input  logic [TW-1:0] cfg_rd_wid,
  input  logic [TW-1:0] cfg_smp_dly,
  input  logic [TW-1:0] cfg_wr_dly,
  input  logic [TW-1:0] cfg_wr_wid,
  input  logic [TW-1:0] cfg_wd_dly,
  input  logic [TW-1:0] cfg_wd_wid,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_valid,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          config_error
);
  logic          busy, nxt_busy, accept;
  logic [TW-1:0] tick, nxt_tick, last;
  logic          dir_q, nxt_dir;
  logic [AW-1:0] addr_q, nxt_addr;
  logic [DW-1:0] wdata_q, nxt_wdata, rd_q;

  logic [TW-1:0]      win_dly [NUM_WIN];
  logic [TW-1:0]      win_wid [NUM_WIN];
  logic [NUM_WIN-1:0] win_en, win_act;

  bct_cfg_check #(.TW(TW)) u_cfg (
    .total(cfg_total), .addr_dly(cfg_addr_dly),
    .rd_dly(cfg_rd_dly), .rd_wid(cfg_rd_wid), .smp_dly(cfg_smp_dly),
    .wr_dly(cfg_wr_dly), .wr_wid(cfg_wr_wid),
    .wd_dly(cfg_wd_dly), .wd_wid(cfg_wd_wid),
    .err(config_error)
  );

  assign req_ready = !busy && !config_error;
  assign accept    = req_valid && req_ready;
  assign last      = cfg_total - 1'b1;

  bct_sequencer #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .last(last),
    .busy(busy), .tick(tick), .nxt_busy(nxt_busy), .nxt_tick(nxt_tick),
    .done(done)
  );

  assign nxt_dir   = accept ? req_write : dir_q;
  assign nxt_addr  = accept ? req_addr  : addr_q;
  assign nxt_wdata = accept ? req_wdata : wdata_q;

  always_comb begin
    win_dly[WIN_ADDR] = cfg_addr_dly;
    win_wid[WIN_ADDR] = cfg_total - cfg_addr_dly;
    win_dly[WIN_RD]   = cfg_rd_dly;
    win_wid[WIN_RD]   = cfg_rd_wid;
    win_dly[WIN_WR]   = cfg_wr_dly;
    win_wid[WIN_WR]   = cfg_wr_wid;
    win_dly[WIN_WD]   = cfg_wd_dly;
    win_wid[WIN_WD]   = cfg_wd_wid;
    win_en[WIN_ADDR]  = nxt_busy;
    win_en[WIN_RD]    = nxt_busy && !nxt_dir;
    win_en[WIN_WR]    = nxt_busy && nxt_dir;
    win_en[WIN_WD]    = nxt_busy && nxt_dir;
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    bct_window #(.TW(TW)) u_win (
      .en(win_en[gi]), .tick(nxt_tick),
      .dly(win_dly[gi]), .wid(win_wid[gi]),
      .active(win_act[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q          <= 1'b0;
      addr_q         <= '0;
      wdata_q        <= '0;
      rd_q           <= '0;
      bus_addr       <= '0;
      bus_addr_valid <= 1'b0;
      bus_rd_n       <= 1'b1;
      bus_wr_n       <= 1'b1;
      bus_wdata      <= '0;
      bus_wdata_oe   <= 1'b0;
    end else begin
      dir_q          <= nxt_dir;
      addr_q         <= nxt_addr;
      wdata_q        <= nxt_wdata;
      bus_addr_valid <= win_act[WIN_ADDR];
      bus_addr       <= win_act[WIN_ADDR] ? nxt_addr : '0;
      bus_rd_n       <= !win_act[WIN_RD];
      bus_wr_n       <= !win_act[WIN_WR];
      bus_wdata_oe   <= win_act[WIN_WD];
      bus_wdata      <= win_act[WIN_WD] ? nxt_wdata : '0;
      if (busy && !dir_q && (tick == cfg_smp_dly)) rd_q <= bus_rdata;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bus_cycle_timer_sva.sv
module bus_cycle_timer_sva #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          config_error,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_addr_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wdata_oe,
  input logic          done
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_rd_n && bus_wr_n && !bus_addr_valid)); // R2
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !req_ready); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_valid && $past(bus_addr_valid)) |-> $stable(bus_addr)); // R1
  AST_WR_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && !config_error) |-> bus_wdata_oe); // R6
endmodule

bind bus_cycle_timer bus_cycle_timer_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .config_error(config_error),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr_valid(bus_addr_valid),
  .bus_addr(bus_addr), .bus_wdata_oe(bus_wdata_oe), .done(done)
);

// File: tb/bus_cycle_timer_test.sv
module bus_cycle_timer_test;
  localparam int TW = 6, AW = 16, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] cfg_total, cfg_addr_dly, cfg_rd_dly, cfg_rd_wid, cfg_smp_dly;
  logic [TW-1:0] cfg_wr_dly, cfg_wr_wid, cfg_wd_dly, cfg_wd_wid;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0, bus_addr;
  logic [DW-1:0] req_wdata = '0, bus_wdata, bus_rdata = '0, rd_data;
  logic bus_addr_valid, bus_rd_n, bus_wr_n, bus_wdata_oe, done, config_error;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bus_cycle_timer #(.TW(TW), .AW(AW), .DW(DW)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int tot, ad, rdd, rdw, smp, wrd, wrw, wdd, wdw);
    cfg_total = TW'(tot); cfg_addr_dly = TW'(ad);
    cfg_rd_dly = TW'(rdd); cfg_rd_wid = TW'(rdw); cfg_smp_dly = TW'(smp);
    cfg_wr_dly = TW'(wrd); cfg_wr_wid = TW'(wrw);
    cfg_wd_dly = TW'(wdd); cfg_wd_wid = TW'(wdw);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_rd_n && bus_wr_n, "R9 reset strobes", {bus_rd_n, bus_wr_n}, 3);
    chk(!bus_addr_valid && !bus_wdata_oe && !done, "R9 reset idle outputs",
        {bus_addr_valid, bus_wdata_oe, done}, 0);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
  endtask

  task automatic run_cycle(input bit wr, input int addr, input int data);
    int tot = int'(cfg_total);
    int base = 16'hA000 + (addr & 16'hff0);
    bit exp_av, exp_rd, exp_wr, exp_oe;
    chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_wdata = DW'(data);
    @(negedge clk);
    req_valid = 1'b0; req_addr = '1; req_wdata = '1;
    for (int k = 0; k < tot; k++) begin
      bus_rdata = DW'(base + k);
      exp_av = k >= int'(cfg_addr_dly);
      exp_rd = !wr && k >= int'(cfg_rd_dly) && k < int'(cfg_rd_dly) + int'(cfg_rd_wid);
      exp_wr = wr && k >= int'(cfg_wr_dly) && k < int'(cfg_wr_dly) + int'(cfg_wr_wid);
      exp_oe = wr && k >= int'(cfg_wd_dly) && k < int'(cfg_wd_dly) + int'(cfg_wd_wid);
      chk(bus_addr_valid == exp_av, "R1 addr valid", bus_addr_valid, exp_av);
      chk(int'(bus_addr) == (exp_av ? addr : 0), "R1 addr value", bus_addr, exp_av ? addr : 0);
      chk(bus_rd_n == !exp_rd, "R3 read strobe", bus_rd_n, !exp_rd);
      chk(bus_wr_n == !exp_wr, "R5 write strobe", bus_wr_n, !exp_wr);
      chk(bus_wdata_oe == exp_oe, "R6 data enable", bus_wdata_oe, exp_oe);
      chk(int'(bus_wdata) == (exp_oe ? data : 0), "R6 data value", bus_wdata, exp_oe ? data : 0);
      chk(!done && !req_ready, "R2 busy during cycle", {done, req_ready}, 0);
      @(negedge clk);
    end
    chk(done == 1'b1, "R2 done after last tick", done, 1);
    chk(bus_rd_n && bus_wr_n && !bus_addr_valid, "R2 bus idle at done",
        {bus_rd_n, bus_wr_n, bus_addr_valid}, 6);
    if (!wr) chk(int'(rd_data) == base + int'(cfg_smp_dly), "R4 captured data",
                 rd_data, base + int'(cfg_smp_dly));
    @(negedge clk);
    chk(done == 1'b0, "R2 done one clock", done, 0);
    if (!wr) chk(int'(rd_data) == base + int'(cfg_smp_dly), "R4 data held",
                 rd_data, base + int'(cfg_smp_dly));
  endtask

  task automatic t_read_nominal();
    set_cfg(10, 1, 2, 5, 6, 3, 3, 2, 6);
    @(negedge clk);
    run_cycle(1'b0, 16'h1230, 0);
  endtask

  task automatic t_write_nominal();
    set_cfg(10, 1, 2, 5, 6, 3, 3, 2, 6);
    @(negedge clk);
    run_cycle(1'b1, 16'h4560, 16'hBEEF);
  endtask

  task automatic t_tight_edges();
    set_cfg(4, 0, 0, 4, 3, 0, 3, 0, 4);
    @(negedge clk);
    chk(config_error == 1'b0, "R7 tight legal", config_error, 0);
    run_cycle(1'b0, 16'h0780, 0);
    run_cycle(1'b1, 16'h09A0, 16'h5A5A);
  endtask

  task automatic t_cfg_errors();
    set_cfg(8, 1, 2, 3, 8, 3, 2, 2, 4);
    @(negedge clk);
    chk(config_error == 1'b1, "R7 sample at length", config_error, 1);
    chk(req_ready == 1'b0, "R8 ready blocked", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h7777;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(bus_rd_n && bus_wr_n && !bus_addr_valid && !done, "R8 request ignored",
          {bus_rd_n, bus_wr_n, bus_addr_valid, done}, 12);
    end
    req_valid = 1'b0;
    set_cfg(8, 1, 2, 3, 5, 3, 2, 4, 3);
    @(negedge clk);
    chk(config_error == 1'b1, "R7 data starts after strobe", config_error, 1);
    set_cfg(8, 1, 2, 3, 5, 3, 2, 2, 3);
    @(negedge clk);
    chk(config_error == 1'b1, "R7 no hold after strobe", config_error, 1);
    set_cfg(8, 1, 2, 7, 5, 3, 2, 2, 4);
    @(negedge clk);
    chk(config_error == 1'b1, "R7 read strobe past end", config_error, 1);
    set_cfg(8, 1, 2, 3, 5, 3, 2, 2, 4);
    @(negedge clk);
    chk(config_error == 1'b0, "R7 legal setting clears", config_error, 0);
    chk(req_ready == 1'b1, "R8 ready restored", req_ready, 1);
    run_cycle(1'b0, 16'h2220, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_cfg(10, 1, 2, 5, 6, 3, 3, 2, 6);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_nominal();
    t_write_nominal();
    t_tight_edges();
    t_cfg_errors();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule